// File: doc/BRIEF.md
# Packed SIMD Arithmetic and Dot-Product Unit

This execution unit works on pairs of 32-bit words that hold packed signed data. A lane-size select picks the view: four signed 8-bit lanes or two signed 16-bit lanes. Lane-wise operations act on each lane on its own and never carry into a neighbour. The available operations are add, subtract, average, minimum, maximum, absolute value, arithmetic shift and the three bitwise logic operations. Dot-product operations multiply the lanes pairwise and reduce them into one 32-bit sum. That sum is either returned alone or added to an accumulator word. A third variant multiplies every lane of the first operand by one scalar, lane 0 of the second operand, copied to all lanes.

The unit also has scalar operations. A fixed-point multiply-accumulate and multiply-subtract work on the low halfwords, followed by a right-shift normalization with optional rounding. A scalar clip limits a word to a symmetric power-of-two range.

An issuing pipeline presents an opcode, the lane select, a round enable, two source words, an accumulator word and a shift amount, with a valid strobe. The result appears in a register one clock later, together with a valid flag. Decode, operand fetch and hazard handling stay with the pipeline around the unit.

Top module: `simd_dot_unit`

## Requirements
- R1: A synchronous reset clears `result` and `outValid`. When `inValid` is high at a clock edge, `result` takes the computed value and `outValid` is high after that edge. When `inValid` is low, `outValid` is low after the edge and `result` keeps its value.
- R2: `opcode` 0 (add) and 1 (subtract) work per lane with wraparound. Lanes are bytes when `laneHalf` is 0 and halfwords when it is 1. Lane k occupies bits [k*w +: w].
- R3: `opcode` 2 (average) gives (a+b) shifted right arithmetically by one in each lane. The sum is formed one bit wider than the lane, so it neither wraps nor saturates.
- R4: `opcode` 3 gives the signed minimum per lane and `opcode` 4 gives the signed maximum per lane.
- R5: `opcode` 5 gives the absolute value of each `srcA` lane. `srcB` is ignored. The most negative lane value maps to itself.
- R6: `opcode` 6 shifts each `srcA` lane right arithmetically by the low 3 bits of `shamt` (byte lanes) or the low 4 bits (halfword lanes). `opcode` 7, 8 and 9 give the bitwise AND, OR and XOR of the full words.
- R7: `opcode` 10 gives the sum of the signed pairwise lane products. Each product is sign-extended to 32 bits before the sum, and the sum wraps at 32 bits.
- R8: `opcode` 11 gives `acc` plus the dot product of R7, wrapping at 32 bits.
- R9: `opcode` 12 multiplies every `srcA` lane by the signed lane 0 of `srcB` and sums the products without `acc`. A scalar of 1 therefore returns the sum of the lanes.
- R10: `opcode` 13 forms `acc` + p and `opcode` 14 forms `acc` - p, where p is the signed product of the low 16 bits of `srcA` and `srcB`. The upper halves of the sources are ignored. The 32-bit result is shifted right arithmetically by `shamt`. When `roundEn` is 1 and `shamt` is not 0, 2^(`shamt`-1) is added first, in a 33-bit intermediate.
- R11: `opcode` 15 clips `srcA` to the range [-2^`shamt`, 2^`shamt`-1]. When `shamt` is 31, `srcA` passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation presented this cycle |
| opcode | input | 4 | Operation select |
| laneHalf | input | 1 | 0: four byte lanes, 1: two halfword lanes |
| roundEn | input | 1 | Rounding enable for multiply-accumulate |
| srcA | input | 32 | First source word |
| srcB | input | 32 | Second source word |
| acc | input | 32 | Accumulator word |
| shamt | input | 5 | Shift, normalization or clip amount |
| result | output | 32 | Registered result |
| outValid | output | 1 | Result updated on the last edge |

## Verification
The bench drives lane values at the sign boundary: 0x7F plus 1, 0x80 less 1, and the most negative lane in abs and average. A unit that let carries cross lanes, or that formed the average in lane width, would corrupt a neighbour lane or flip the sign of the average. The dot-product cases use all-0x80 operands. A sum taken at product width would lose the 0x10000 total for bytes. A replicated-scalar unit that used the wrong lane of `srcB` would return a sum scaled by the wrong factor. The multiply-accumulate cases cover the following:
- rounding of negative sums;
- garbage in the upper source halves;
- a near-maximum accumulator, where a 32-bit rounding add would wrap to a negative value.

The clip cases cover `shamt` 0 and 31, and idle cycles check that the result register holds.

// File: rtl/simd_dot_pkg.sv
package simd_dot_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AVG   = 4'd2,
    OP_MIN   = 4'd3,
    OP_MAX   = 4'd4,
    OP_ABS   = 4'd5,
    OP_SRA   = 4'd6,
    OP_AND   = 4'd7,
    OP_OR    = 4'd8,
    OP_XOR   = 4'd9,
    OP_DOTP  = 4'd10,
    OP_SDOTP = 4'd11,
    OP_DOTSC = 4'd12,
    OP_MAC   = 4'd13,
    OP_MSU   = 4'd14,
    OP_CLIP  = 4'd15
  } opcode_e;

  typedef enum logic [2:0] {
    K_LANE,
    K_LOGIC,
    K_DOT,
    K_MAC,
    K_CLIP
  } kind_e;

  typedef enum logic [2:0] {
    L_ADD,
    L_SUB,
    L_AVG,
    L_MIN,
    L_MAX,
    L_ABS,
    L_SRA
  } lane_e;

  typedef enum logic [1:0] {
    G_AND,
    G_OR,
    G_XOR
  } logic_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   load;
    kind_e  kind;
    lane_e  laneOp;
    logic_e logicOp;
    logic   laneHalf;
    logic   useAcc;
    logic   negate;
    logic   replicate;
    logic   roundEn;
  } strobe_t;

endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_dot_pkg::*;
#(
  parameter int W = 8,
  localparam int SH = $clog2(W)
) (
  input  lane_e                 laneOp,
  input  logic [W-1:0]          a,
  input  logic [W-1:0]          b,
  input  logic [W-1:0]          bDot,
  input  logic [SH-1:0]         sh,
  output logic [W-1:0]          res,
  output logic signed [2*W-1:0] prod
);

  logic signed [W-1:0] sa;
  logic signed [W-1:0] sb;
  logic signed [W-1:0] sd;
  logic [W:0]          sumWide;
  logic [W:0]          diffWide;

  assign sa = a;
  assign sb = b;
  assign sd = bDot;

  // One extra bit so the average never wraps
  assign sumWide  = {a[W-1], a} + {b[W-1], b};
  assign diffWide = {a[W-1], a} - {b[W-1], b};

  assign prod = (2*W)'(sa) * (2*W)'(sd);

  always_comb begin
    unique case (laneOp)
      L_ADD:   res = sumWide[W-1:0];
      L_SUB:   res = diffWide[W-1:0];
      L_AVG:   res = sumWide[W:1];
      L_MIN:   res = (sa < sb) ? a : b;
      L_MAX:   res = (sa > sb) ? a : b;
      L_ABS:   res = sa[W-1] ? (~a + 1'b1) : a;
      L_SRA:   res = W'(sa >>> sh);
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/simd_dot_ctrl.sv
module simd_dot_ctrl
  import simd_dot_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [3:0] opcode,
  input  logic       laneHalf,
  input  logic       roundEn,
  output strobe_t    st,
  output logic       outValid
);

  always_comb begin
    st           = '0;
    st.load      = inValid;
    st.laneHalf  = laneHalf;
    st.roundEn   = roundEn;
    st.kind      = K_LANE;
    st.laneOp    = L_ADD;
    st.logicOp   = G_AND;
    unique case (opcode_e'(opcode))
      OP_ADD:   st.laneOp = L_ADD;
      OP_SUB:   st.laneOp = L_SUB;
      OP_AVG:   st.laneOp = L_AVG;
      OP_MIN:   st.laneOp = L_MIN;
      OP_MAX:   st.laneOp = L_MAX;
      OP_ABS:   st.laneOp = L_ABS;
      OP_SRA:   st.laneOp = L_SRA;
      OP_AND:   begin st.kind = K_LOGIC; st.logicOp = G_AND; end
      OP_OR:    begin st.kind = K_LOGIC; st.logicOp = G_OR;  end
      OP_XOR:   begin st.kind = K_LOGIC; st.logicOp = G_XOR; end
      OP_DOTP:  st.kind = K_DOT;
      OP_SDOTP: begin st.kind = K_DOT; st.useAcc = 1'b1; end
      OP_DOTSC: begin st.kind = K_DOT; st.replicate = 1'b1; end
      OP_MAC:   st.kind = K_MAC;
      OP_MSU:   begin st.kind = K_MAC; st.negate = 1'b1; end
      OP_CLIP:  st.kind = K_CLIP;
      default:  st.kind = K_LANE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  AST_LOAD_FLAGS_VALID: assert property (@(posedge clk) disable iff (rst)
    st.load |=> outValid); // R1
  AST_IDLE_CLEARS_VALID: assert property (@(posedge clk) disable iff (rst)
    !st.load |=> !outValid); // R1

endmodule

// File: rtl/simd_dot_datapath.sv
module simd_dot_datapath
  import simd_dot_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SHAMT_W = $clog2(DATA_W),
  localparam int NB = DATA_W / 8,
  localparam int NH = DATA_W / 16,
  localparam int MAC_W = DATA_W / 2
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            st,
  input  logic [DATA_W-1:0]  srcA,
  input  logic [DATA_W-1:0]  srcB,
  input  logic [DATA_W-1:0]  acc,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  result
);

  logic [DATA_W-1:0] laneB;
  logic [DATA_W-1:0] laneH;
  logic signed [15:0] prodB [NB];
  logic signed [31:0] prodH [NH];

  // Byte lanes
  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [7:0] bDot;
    assign bDot = st.replicate ? srcB[7:0] : srcB[8*i +: 8];
    simd_lane #(.W(8)) u_lane (
      .laneOp (st.laneOp),
      .a      (srcA[8*i +: 8]),
      .b      (srcB[8*i +: 8]),
      .bDot   (bDot),
      .sh     (shamt[2:0]),
      .res    (laneB[8*i +: 8]),
      .prod   (prodB[i])
    );
  end

  // Halfword lanes
  for (genvar j = 0; j < NH; j++) begin : g_half
    logic [15:0] bDot;
    assign bDot = st.replicate ? srcB[15:0] : srcB[16*j +: 16];
    simd_lane #(.W(16)) u_lane (
      .laneOp (st.laneOp),
      .a      (srcA[16*j +: 16]),
      .b      (srcB[16*j +: 16]),
      .bDot   (bDot),
      .sh     (shamt[3:0]),
      .res    (laneH[16*j +: 16]),
      .prod   (prodH[j])
    );
  end

  // Dot-product reduction, products sign-extended to the word
  logic [DATA_W-1:0] dotB;
  logic [DATA_W-1:0] dotH;
  logic [DATA_W-1:0] dotOut;

  always_comb begin
    dotB = '0;
    for (int i = 0; i < NB; i++) dotB = dotB + DATA_W'(prodB[i]);
    dotH = '0;
    for (int j = 0; j < NH; j++) dotH = dotH + DATA_W'(prodH[j]);
    dotOut = (st.useAcc ? acc : '0) + (st.laneHalf ? dotH : dotB);
  end

  // Multiply-accumulate with normalization and rounding
  logic signed [DATA_W-1:0] macProd;
  logic [DATA_W-1:0]        macSum;
  logic signed [DATA_W:0]   macExt;
  logic signed [DATA_W:0]   rndAdd;
  logic signed [DATA_W:0]   macShifted;

  assign macProd = DATA_W'($signed(srcA[MAC_W-1:0])) * DATA_W'($signed(srcB[MAC_W-1:0]));
  assign macSum  = st.negate ? (acc - macProd) : (acc + macProd);
  assign macExt  = {macSum[DATA_W-1], macSum};

  always_comb begin
    rndAdd = '0;
    if (st.roundEn && (shamt != '0)) rndAdd[shamt - 1'b1] = 1'b1;
  end

  assign macShifted = (macExt + rndAdd) >>> shamt;

  // Scalar clip
  logic signed [DATA_W-1:0] clipHi;
  logic signed [DATA_W-1:0] clipLo;
  logic [DATA_W-1:0]        clipOut;

  always_comb begin
    clipHi = (DATA_W'(1) << shamt) - DATA_W'(1);
    clipLo = ~clipHi;
    if (shamt >= SHAMT_W'(DATA_W - 1))       clipOut = srcA;
    else if ($signed(srcA) > clipHi)         clipOut = clipHi;
    else if ($signed(srcA) < clipLo)         clipOut = clipLo;
    else                                     clipOut = srcA;
  end

  // Result select and register
  logic [DATA_W-1:0] nextResult;
  logic [DATA_W-1:0] logicOut;

  always_comb begin
    unique case (st.logicOp)
      G_AND:   logicOut = srcA & srcB;
      G_OR:    logicOut = srcA | srcB;
      G_XOR:   logicOut = srcA ^ srcB;
      default: logicOut = '0;
    endcase
    unique case (st.kind)
      K_LANE:  nextResult = st.laneHalf ? laneH : laneB;
      K_LOGIC: nextResult = logicOut;
      K_DOT:   nextResult = dotOut;
      K_MAC:   nextResult = macShifted[DATA_W-1:0];
      K_CLIP:  nextResult = clipOut;
      default: nextResult = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          result <= '0;
    else if (st.load) result <= nextResult;
  end

  AST_IDLE_HOLDS_RESULT: assert property (@(posedge clk) disable iff (rst)
    !st.load |=> $stable(result)); // R1
  AST_AND_ZERO_MASK: assert property (@(posedge clk) disable iff (rst)
    (st.load && st.kind == K_LOGIC && st.logicOp == G_AND && srcB == '0) |=> (result == '0)); // R6
  AST_SDOTP_ZERO_SRC: assert property (@(posedge clk) disable iff (rst)
    (st.load && st.kind == K_DOT && st.useAcc && srcA == '0) |=> (result == $past(acc))); // R8
  AST_CLIP_UNIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (st.load && st.kind == K_CLIP && shamt == '0) |=> (result == '0 || result == '1)); // R11

endmodule

// File: rtl/simd_dot_unit.sv
module simd_dot_unit
  import simd_dot_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [3:0]         opcode,
  input  logic               laneHalf,
  input  logic               roundEn,
  input  logic [DATA_W-1:0]  srcA,
  input  logic [DATA_W-1:0]  srcB,
  input  logic [DATA_W-1:0]  acc,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  result,
  output logic               outValid
);

  strobe_t st;

  simd_dot_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .opcode   (opcode),
    .laneHalf (laneHalf),
    .roundEn  (roundEn),
    .st       (st),
    .outValid (outValid)
  );

  simd_dot_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .st     (st),
    .srcA   (srcA),
    .srcB   (srcB),
    .acc    (acc),
    .shamt  (shamt),
    .result (result)
  );

endmodule

// File: tb/simd_dot_unit_test.sv
module simd_dot_unit_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [3:0]  opcode;
  logic        laneHalf;
  logic        roundEn;
  logic [31:0] srcA, srcB, acc;
  logic [4:0]  shamt;
  logic [31:0] result;
  logic        outValid;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  simd_dot_unit uut (
    .clk(clk), .rst(rst), .inValid(inValid), .opcode(opcode),
    .laneHalf(laneHalf), .roundEn(roundEn), .srcA(srcA), .srcB(srcB),
    .acc(acc), .shamt(shamt), .result(result), .outValid(outValid)
  );

  function automatic int sx(logic [31:0] v, int w);
    if (w == 8) return int'($signed(v[7:0]));
    return int'($signed(v[15:0]));
  endfunction

  // Expected value from the requirements
  function automatic logic [31:0] model(int op, bit half, logic [31:0] a, logic [31:0] b,
                                        logic [31:0] ac, int sh, bit rnd);
    int w = half ? 16 : 8;
    int n = half ? 2 : 4;
    logic [31:0] mask = half ? 32'h0000FFFF : 32'h000000FF;
    logic [31:0] res = '0;
    int sum = 0;
    int ai, bi, r;
    if (op <= 6) begin
      for (int k = 0; k < n; k++) begin
        ai = sx(a >> (k*w), w);
        bi = sx(b >> (k*w), w);
        case (op)
          0: r = ai + bi;
          1: r = ai - bi;
          2: r = (ai + bi) >>> 1;
          3: r = (ai < bi) ? ai : bi;
          4: r = (ai > bi) ? ai : bi;
          5: r = (ai < 0) ? -ai : ai;
          default: r = ai >>> (sh & (w-1));
        endcase
        res = res | ((32'(r) & mask) << (k*w));
      end
      return res;
    end
    case (op)
      7: return a & b;
      8: return a | b;
      9: return a ^ b;
      10, 11, 12: begin
        for (int k = 0; k < n; k++) begin
          ai = sx(a >> (k*w), w);
          bi = (op == 12) ? sx(b, w) : sx(b >> (k*w), w);
          sum = sum + ai * bi;
        end
        if (op == 11) sum = sum + int'(ac);
        return 32'(sum);
      end
      13, 14: begin
        longint e;
        int p = sx(a, 16) * sx(b, 16);
        int s = (op == 13) ? int'(ac) + p : int'(ac) - p;
        e = longint'(s);
        if (rnd && sh > 0) e = e + (longint'(1) << (sh - 1));
        e = e >>> sh;
        return e[31:0];
      end
      default: begin
        int hi, lo;
        if (sh >= 31) return a;
        hi = (1 << sh) - 1;
        lo = -(1 << sh);
        if (int'(a) > hi) return 32'(hi);
        if (int'(a) < lo) return 32'(lo);
        return a;
      end
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Present one operation, sample after the registering edge
  task automatic run(string tag, int op, bit half, logic [31:0] a, logic [31:0] b,
                     logic [31:0] ac, int sh, bit rnd);
    @(negedge clk);
    inValid = 1'b1; opcode = 4'(op); laneHalf = half; roundEn = rnd;
    srcA = a; srcB = b; acc = ac; shamt = 5'(sh);
    @(negedge clk);
    inValid = 1'b0;
    check(tag, result, model(op, half, a, b, ac, sh, rnd));
    check({tag, " valid"}, 32'(outValid), 32'd1);
  endtask

  task automatic t_reset;
    check("R1 reset result", result, 32'h0);
    check("R1 reset valid", 32'(outValid), 32'd0);
  endtask

  task automatic t_add_sub;
    run("R2 add bytes", 0, 0, 32'h7F01FF80, 32'h01FF0180, 0, 0, 0);
    check("R2 add bytes const", result, 32'h80000000);
    run("R2 add halves", 0, 1, 32'h7FFF0001, 32'h00010002, 0, 0, 0);
    check("R2 add halves const", result, 32'h80000003);
    run("R2 sub bytes", 1, 0, 32'h00800110, 32'h01010220, 0, 0, 0);
    run("R2 sub halves", 1, 1, 32'h80000000, 32'h00010001, 0, 0, 0);
  endtask

  task automatic t_avg;
    run("R3 avg bytes", 2, 0, 32'h7F80FF03, 32'h7F80FF02, 0, 0, 0);
    check("R3 avg bytes const", result, 32'h7F80FF02);
    run("R3 avg halves", 2, 1, 32'h7FFF8000, 32'h0001FFFF, 0, 0, 0);
  endtask

  task automatic t_minmax;
    run("R4 min bytes", 3, 0, 32'h807F0102, 32'h7F80FF03, 0, 0, 0);
    run("R4 max bytes", 4, 0, 32'h807F0102, 32'h7F80FF03, 0, 0, 0);
    run("R4 max halves", 4, 1, 32'h8000FFFF, 32'h7FFF0001, 0, 0, 0);
  endtask

  task automatic t_abs;
    run("R5 abs bytes", 5, 0, 32'h80FF7F05, 32'hDEADBEEF, 0, 0, 0);
    check("R5 abs bytes const", result, 32'h80017F05);
    run("R5 abs halves", 5, 1, 32'h8000FFFE, 32'h12345678, 0, 0, 0);
  endtask

  task automatic t_shift_logic;
    run("R6 sra bytes", 6, 0, 32'h80407FF0, 0, 0, 9, 0);
    run("R6 sra halves", 6, 1, 32'h80007FFF, 0, 0, 20, 0);
    run("R6 and", 7, 0, 32'hF0F0AAAA, 32'hFF00FFFF, 0, 0, 0);
    run("R6 or", 8, 1, 32'hF0F00000, 32'h0F0F1234, 0, 0, 0);
    run("R6 xor", 9, 0, 32'hFFFF0000, 32'h0F0F0F0F, 0, 0, 0);
  endtask

  task automatic t_dot;
    run("R7 dot bytes", 10, 0, 32'h80808080, 32'h80808080, 32'h5555, 0, 0);
    check("R7 dot bytes const", result, 32'h00010000);
    run("R7 dot halves", 10, 1, 32'h80008000, 32'h80008000, 0, 0, 0);
    run("R7 dot mixed", 10, 0, 32'h01FF02FE, 32'h03040506, 0, 0, 0);
  endtask

  task automatic t_sdotp;
    run("R8 sdotp bytes", 11, 0, 32'h01020304, 32'h05060708, 32'd100, 0, 0);
    check("R8 sdotp const", result, 32'd170);
    run("R8 sdotp halves", 11, 1, 32'hFFFF0002, 32'h00030004, 32'hFFFFFFF0, 0, 0);
  endtask

  task automatic t_dotsc;
    run("R9 dotsc sum bytes", 12, 0, 32'h01020304, 32'hAAAAAA01, 32'd999, 0, 0);
    check("R9 dotsc sum const", result, 32'd10);
    run("R9 dotsc halves", 12, 1, 32'hFFFF0005, 32'h12340002, 0, 0, 0);
    check("R9 dotsc halves const", result, 32'd8);
  endtask

  task automatic t_mac;
    run("R10 mac plain", 13, 0, 32'hABCD0003, 32'h12340005, 32'd100, 0, 1);
    check("R10 mac const", result, 32'd115);
    run("R10 msu plain", 14, 1, 32'hABCD0003, 32'h12340005, 32'd100, 0, 0);
    run("R10 mac round", 13, 0, 32'h1, 32'h1, 32'd10, 2, 1);
    run("R10 mac trunc", 13, 0, 32'h1, 32'h1, 32'd10, 2, 0);
    run("R10 msu neg round", 14, 0, 32'h1, 32'h1, 32'hFFFFFFF8, 2, 1);
    run("R10 mac wide round", 13, 0, 32'h0, 32'h0, 32'h7FFFFFFF, 1, 1);
    check("R10 wide round const", result, 32'h40000000);
  endtask

  task automatic t_clip;
    run("R11 clip high", 15, 0, 32'd1000, 0, 0, 7, 0);
    check("R11 clip high const", result, 32'd127);
    run("R11 clip low", 15, 0, 32'hFFFFF000, 0, 0, 7, 0);
    run("R11 clip zero", 15, 0, 32'hFFFFFF00, 0, 0, 0, 0);
    run("R11 clip full", 15, 0, 32'h80000000, 0, 0, 31, 0);
  endtask

  task automatic t_idle;
    logic [31:0] held;
    held = result;
    @(negedge clk);
    inValid = 1'b0; opcode = 4'd8; srcA = 32'hFFFFFFFF; srcB = 32'hFFFFFFFF;
    @(negedge clk);
    @(negedge clk);
    check("R1 idle holds result", result, held);
    check("R1 idle valid low", 32'(outValid), 32'd0);
  endtask

  initial begin
    rst = 1'b1; inValid = 1'b0; opcode = '0; laneHalf = 1'b0; roundEn = 1'b0;
    srcA = '0; srcB = '0; acc = '0; shamt = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    t_add_sub;
    t_avg;
    t_minmax;
    t_abs;
    t_shift_logic;
    t_dot;
    t_sdotp;
    t_dotsc;
    t_mac;
    t_clip;
    t_idle;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule